// File: doc/BRIEF.md
# Interrupt and Status Register Unit

This unit keeps the interrupt-cause, status and sequence-step registers of a bus controller's register file. It also drives the single level-sensitive interrupt line to the host. Other logic in the controller reports events to it: a strobe that loads a cause code, status bits and a step number, a request to raise the interrupt, and a request to lower it. Two-bit command codes cover bus reset and the enable-selection and disable-selection commands.

The host reads through a combinational read port. Reading the interrupt-cause register is destructive. The host gets the value held before the read. On the following clock edge the cause register is cleared, the transfer-complete status bit is dropped, the sequence step is forced to the command-done value, and the interrupt is withdrawn. A configuration register holds the bit that suppresses interrupts for bus-reset reports. A soft-reset strobe returns every register to its initial state, and the configuration register then reads 7.

Top module: `isr_unit`

## Requirements
- R1: After `rst`, `irq_o` is 0, the status, cause and step registers read 0, and the configuration register reads 8'h07.
- R2: `ev_load` loads `ev_cause` into the cause register, `ev_stat` into status bits 6:0 and `ev_step` into the 3-bit step register. The new values are readable from the next cycle.
- R3: `ev_raise` sets `irq_o` and status bit 7 together on the next cycle. A raise while the interrupt is already set leaves both at 1. With no raise and no clear, the interrupt holds.
- R4: The read address map is: status at 4, cause at 5, step at 6 (in bits 2:0) and configuration at 8; all other addresses read 0. `rd_data` shows the addressed value in the same cycle. With `rd_en` at address 5, the value returned is the one held before the read, and the cause register reads 0 afterwards. Reads at any other address change nothing.
- R5: A read of the cause register also clears status bit 4 (transfer complete) and status bit 7, and keeps the other status bits. It loads the step with 4 (command done) and drops `irq_o`.
- R6: `lower_req` clears `irq_o` and status bit 7. When the interrupt is already clear it has no effect.
- R7: `cmd_op` = 1 (bus reset) loads 8'h80 into the cause register. It raises the interrupt only when configuration bit 6 is 0.
- R8: `cmd_op` = 3 (disable selection) clears the cause register and raises the interrupt. `cmd_op` = 2 (enable selection) clears the cause register and does not raise it.
- R9: When an event load or a command falls in the same cycle as a cause-register read, the event's or command's values are kept. A raise in that cycle wins over the read's clear.
- R10: `soft_rst` takes priority over every other input. It drops `irq_o`, clears the status, cause and step registers, and sets the configuration register to 8'h07.
- R11: `cfg_we` loads `cfg_wdata` into the configuration register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Soft-reset strobe |
| ev_load | input | 1 | Load cause, status and step from the event fields |
| ev_raise | input | 1 | Request to raise the interrupt |
| ev_cause | input | 8 | Cause code for an event load |
| ev_stat | input | 7 | Status bits 6:0 for an event load |
| ev_step | input | 3 | Sequence step for an event load |
| cmd_op | input | 2 | 0 none, 1 bus reset, 2 enable selection, 3 disable selection |
| lower_req | input | 1 | Request to lower the interrupt |
| rd_en | input | 1 | Host read strobe; the side effects apply at address 5 |
| rd_addr | input | 4 | Host read address |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| rd_data | output | 8 | Read data for `rd_addr` |
| irq_o | output | 1 | Level interrupt to the host |

## Verification
The bench uses the default parameters. These are an 8-bit register width, a 3-bit step and a 4-bit read address. Every decoded and undecoded address is therefore hit by random reads, including reads with no side effects and destructive reads that collide with events and commands. Random configuration writes switch bit 6 back and forth, so bus-reset commands are tried both with and without interrupt reporting. Directed cases cover the same-cycle priority between a read and an event or command, and soft reset arriving together with a raise.

// File: rtl/isr_pkg.sv
package isr_pkg;
    localparam int REG_W  = 8;
    localparam int STEP_W = 3;
    localparam int ADDR_W = 4;
    localparam int STAT_W = REG_W - 1;

    localparam logic [ADDR_W-1:0] A_STAT = 4'd4;
    localparam logic [ADDR_W-1:0] A_INTR = 4'd5;
    localparam logic [ADDR_W-1:0] A_SEQ  = 4'd6;
    localparam logic [ADDR_W-1:0] A_CFG1 = 4'd8;

    localparam int ST_DONE_BIT   = 4;
    localparam int CFG_QUIET_BIT = 6;

    localparam logic [REG_W-1:0]  CAUSE_BUSRST  = 8'h80;
    localparam logic [REG_W-1:0]  CFG1_INIT     = 8'h07;
    localparam logic [STEP_W-1:0] STEP_CMD_DONE = 3'd4;

    typedef enum logic [1:0] {
        OP_NONE    = 2'd0,
        OP_BUSRST  = 2'd1,
        OP_SEL_EN  = 2'd2,
        OP_SEL_DIS = 2'd3
    } host_op_e;

    typedef struct packed {
        logic [REG_W-1:0]  cause;
        logic [STAT_W-1:0] stat;
        logic [STEP_W-1:0] step;
    } isr_state_t;

    function automatic logic op_raises(host_op_e op, logic [REG_W-1:0] cfg);
        return (op == OP_SEL_DIS) || (op == OP_BUSRST && !cfg[CFG_QUIET_BIT]);
    endfunction
endpackage

// File: rtl/isr_irq_ctl.sv
module isr_irq_ctl (
    input  logic clk,
    input  logic rst,
    input  logic soft_rst,
    input  logic raise,
    input  logic clear,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst || soft_rst) irq <= 1'b0;
        else if (raise)      irq <= 1'b1;
        else if (clear)      irq <= 1'b0;
    end

    assert_raise_sets_R3: assert property (@(posedge clk) disable iff (rst)
        (raise && !soft_rst) |=> irq);
    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!raise && !clear && !soft_rst) |=> $stable(irq));
    assert_lower_clears_R6: assert property (@(posedge clk) disable iff (rst)
        (clear && !raise) |=> !irq);
    assert_soft_drop_R10: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> !irq);
endmodule

// File: rtl/isr_cfg_reg.sv
module isr_cfg_reg
    import isr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             soft_rst,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] cfg
);
    always_ff @(posedge clk) begin
        if (rst || soft_rst) cfg <= CFG1_INIT;
        else if (we)         cfg <= wdata;
    end

    assert_soft_cfg_R10: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (cfg == CFG1_INIT));
    assert_cfg_write_R11: assert property (@(posedge clk) disable iff (rst)
        (we && !soft_rst) |=> (cfg == $past(wdata)));
endmodule

// File: rtl/isr_regs.sv
module isr_regs
    import isr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       soft_rst,
    input  logic       ev_load,
    input  isr_state_t ev,
    input  host_op_e   op,
    input  logic       intr_rd,
    output isr_state_t st
);
    isr_state_t nxt;

    always_comb begin
        nxt = st;
        if (intr_rd) begin
            nxt.cause             = '0;
            nxt.stat[ST_DONE_BIT] = 1'b0;
            nxt.step              = STEP_CMD_DONE;
        end
        case (op)
            OP_BUSRST:             nxt.cause = CAUSE_BUSRST;
            OP_SEL_EN, OP_SEL_DIS: nxt.cause = '0;
            default: ;
        endcase
        if (ev_load) nxt = ev;
    end

    always_ff @(posedge clk) begin
        if (rst || soft_rst) st <= '0;
        else                 st <= nxt;
    end

    assert_read_side_R5: assert property (@(posedge clk) disable iff (rst)
        (intr_rd && !ev_load && op == OP_NONE && !soft_rst)
        |=> (st.cause == '0 && st.step == STEP_CMD_DONE && !st.stat[ST_DONE_BIT]));
    assert_event_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (ev_load && !soft_rst) |=> (st == $past(ev)));
    assert_busrst_cause_R7: assert property (@(posedge clk) disable iff (rst)
        (op == OP_BUSRST && !ev_load && !soft_rst) |=> (st.cause == CAUSE_BUSRST));
    assert_soft_clear_R10: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (st == '0));
endmodule

// File: rtl/isr_unit.sv
module isr_unit
    import isr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic              ev_load,
    input  logic              ev_raise,
    input  logic [REG_W-1:0]  ev_cause,
    input  logic [STAT_W-1:0] ev_stat,
    input  logic [STEP_W-1:0] ev_step,
    input  logic [1:0]        cmd_op,
    input  logic              lower_req,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              cfg_we,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  rd_data,
    output logic              irq_o
);
    host_op_e   op;
    isr_state_t ev, st;
    logic [REG_W-1:0] cfg;
    logic intr_rd, raise, clear;

    assign op      = host_op_e'(cmd_op);
    assign ev      = '{cause: ev_cause, stat: ev_stat, step: ev_step};
    assign intr_rd = rd_en && (rd_addr == A_INTR);
    assign raise   = ev_raise || op_raises(op, cfg);
    assign clear   = intr_rd || lower_req;

    isr_regs u_regs (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .ev_load(ev_load),
        .ev(ev), .op(op), .intr_rd(intr_rd), .st(st)
    );

    isr_irq_ctl u_irq (
        .clk(clk), .rst(rst), .soft_rst(soft_rst),
        .raise(raise), .clear(clear), .irq(irq_o)
    );

    isr_cfg_reg u_cfg (
        .clk(clk), .rst(rst), .soft_rst(soft_rst),
        .we(cfg_we), .wdata(cfg_wdata), .cfg(cfg)
    );

    always_comb begin
        case (rd_addr)
            A_STAT:  rd_data = {irq_o, st.stat};
            A_INTR:  rd_data = st.cause;
            A_SEQ:   rd_data = {{(REG_W-STEP_W){1'b0}}, st.step};
            A_CFG1:  rd_data = cfg;
            default: rd_data = '0;
        endcase
    end

    assert_busrst_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (op == OP_BUSRST && cfg[CFG_QUIET_BIT] && !ev_raise && !irq_o && !soft_rst) |=> !irq_o);
    assert_selen_noraise_R8: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SEL_EN && !ev_raise && !irq_o && !soft_rst) |=> !irq_o);
endmodule

// File: tb/test_isr_unit.sv
module test_isr_unit;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst = 1'b1, soft_rst = 1'b0;
    logic ev_load = 1'b0, ev_raise = 1'b0;
    logic [7:0] ev_cause = '0;
    logic [6:0] ev_stat = '0;
    logic [2:0] ev_step = '0;
    logic [1:0] cmd_op = '0;
    logic lower_req = 1'b0, rd_en = 1'b0, cfg_we = 1'b0;
    logic [3:0] rd_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] rd_data;
    logic irq_o;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    logic [7:0] m_intr, m_cfg;
    logic [6:0] m_stat;
    logic [2:0] m_seq;
    logic m_irq;

    isr_unit i_isr_unit (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] mread(logic [3:0] a);
        case (a)
            4'd4: return {m_irq, m_stat};
            4'd5: return m_intr;
            4'd6: return {5'b0, m_seq};
            4'd8: return m_cfg;
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_reset();
        m_intr = 0; m_stat = 0; m_seq = 0; m_irq = 0; m_cfg = 8'h07;
    endtask

    task automatic model_update();
        logic rd5, rs, cl;
        if (rst || soft_rst) begin model_reset(); return; end
        rd5 = rd_en && rd_addr == 4'd5;
        rs = ev_raise || cmd_op == 2'd3 || (cmd_op == 2'd1 && !m_cfg[6]);
        cl = rd5 || lower_req;
        if (rd5) begin m_intr = 0; m_stat[4] = 1'b0; m_seq = 3'd4; end
        if (cmd_op == 2'd1) m_intr = 8'h80;
        else if (cmd_op != 2'd0) m_intr = 0;
        if (ev_load) begin m_intr = ev_cause; m_stat = ev_stat; m_seq = ev_step; end
        if (cfg_we) m_cfg = cfg_wdata;
        if (rs) m_irq = 1'b1; else if (cl) m_irq = 1'b0;
    endtask

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        soft_rst = 0; ev_load = 0; ev_raise = 0; cmd_op = 0;
        lower_req = 0; rd_en = 0; cfg_we = 0;
    endtask

    task automatic step();
        @(posedge clk);
        model_update();
        @(negedge clk);
        idle();
    endtask

    task automatic peek(logic [3:0] a, output logic [7:0] v);
        rd_en = 0; rd_addr = a; #1; v = rd_data;
    endtask

    task automatic chk_reg(string tag, logic [3:0] a, logic [7:0] exp);
        logic [7:0] v;
        peek(a, v);
        chk(tag, v, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hang expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd1234));
        model_reset();
        repeat (2) @(negedge clk);
        rst = 0;
        // R1 reset state
        chk("R1 irq", {7'b0, irq_o}, 8'h00);
        chk_reg("R1 stat", 4'd4, 8'h00);
        chk_reg("R1 intr", 4'd5, 8'h00);
        chk_reg("R1 seq", 4'd6, 8'h00);
        chk_reg("R1 cfg", 4'd8, 8'h07);
        // R2 / R3 event load with raise
        ev_load = 1; ev_raise = 1; ev_cause = 8'h28; ev_stat = 7'h13; ev_step = 3'd2;
        step();
        chk("R3 irq set", {7'b0, irq_o}, 8'h01);
        chk_reg("R3 stat bit7", 4'd4, 8'h93);
        chk_reg("R2 cause", 4'd5, 8'h28);
        chk_reg("R2 step", 4'd6, 8'h02);
        ev_raise = 1; step();
        chk("R3 raise again", {7'b0, irq_o}, 8'h01);
        // R4 non-destructive read at status address
        rd_en = 1; rd_addr = 4'd4; step();
        chk_reg("R4 status read no effect", 4'd5, 8'h28);
        // R4 / R5 destructive read
        rd_en = 1; rd_addr = 4'd5; #1;
        chk("R4 pre-read value", rd_data, 8'h28);
        step();
        chk_reg("R4 cause cleared", 4'd5, 8'h00);
        chk_reg("R5 stat", 4'd4, 8'h03);
        chk_reg("R5 step", 4'd6, 8'h04);
        chk("R5 irq", {7'b0, irq_o}, 8'h00);
        // R6 lower
        lower_req = 1; step();
        chk("R6 lower when clear", {7'b0, irq_o}, 8'h00);
        ev_raise = 1; step();
        lower_req = 1; step();
        chk("R6 lower when set", {7'b0, irq_o}, 8'h00);
        chk_reg("R6 stat bit7", 4'd4, 8'h03);
        // R7 bus reset, reporting on
        cmd_op = 2'd1; step();
        chk_reg("R7 cause", 4'd5, 8'h80);
        chk("R7 irq reported", {7'b0, irq_o}, 8'h01);
        rd_en = 1; rd_addr = 4'd5; step();
        cfg_we = 1; cfg_wdata = 8'h47; step();
        chk_reg("R11 cfg", 4'd8, 8'h47);
        cmd_op = 2'd1; step();
        chk_reg("R7 cause quiet", 4'd5, 8'h80);
        chk("R7 irq quiet", {7'b0, irq_o}, 8'h00);
        // R8 selection commands
        cmd_op = 2'd3; step();
        chk_reg("R8 dis cause", 4'd5, 8'h00);
        chk("R8 dis irq", {7'b0, irq_o}, 8'h01);
        rd_en = 1; rd_addr = 4'd5; step();
        ev_load = 1; ev_cause = 8'h11; ev_stat = 0; ev_step = 0; step();
        cmd_op = 2'd2; step();
        chk_reg("R8 en cause", 4'd5, 8'h00);
        chk("R8 en irq", {7'b0, irq_o}, 8'h00);
        // R9 event with read in the same cycle
        ev_load = 1; ev_raise = 1; ev_cause = 8'h05; ev_stat = 7'h10; ev_step = 3'd1;
        rd_en = 1; rd_addr = 4'd5; step();
        chk_reg("R9 cause", 4'd5, 8'h05);
        chk_reg("R9 stat", 4'd4, 8'h90);
        chk_reg("R9 step", 4'd6, 8'h01);
        cmd_op = 2'd1; rd_en = 1; rd_addr = 4'd5; step();
        chk_reg("R9 cmd over read", 4'd5, 8'h80);
        // R10 soft reset beats a raise
        soft_rst = 1; ev_raise = 1; cfg_we = 1; cfg_wdata = 8'hFF; step();
        chk("R10 irq", {7'b0, irq_o}, 8'h00);
        chk_reg("R10 cause", 4'd5, 8'h00);
        chk_reg("R10 stat", 4'd4, 8'h00);
        chk_reg("R10 cfg", 4'd8, 8'h07);
        // random phase against the model
        for (int i = 0; i < 4000; i++) begin
            ev_load   = ($urandom % 4) == 0;
            ev_raise  = ($urandom % 4) == 0;
            ev_cause  = 8'($urandom);
            ev_stat   = 7'($urandom);
            ev_step   = 3'($urandom);
            cmd_op    = (($urandom % 4) == 0) ? 2'($urandom) : 2'd0;
            lower_req = ($urandom % 8) == 0;
            rd_en     = ($urandom % 2) == 0;
            rd_addr   = 4'($urandom);
            cfg_we    = ($urandom % 16) == 0;
            cfg_wdata = 8'($urandom);
            soft_rst  = ($urandom % 64) == 0;
            #1;
            chk("R4 random read", rd_data, mread(rd_addr));
            chk("R3 random irq", {7'b0, irq_o}, {7'b0, m_irq});
            step();
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule